// File: doc/BRIEF.md
# Packed SIMD Absolute Difference Unit

This datapath block takes two 128-bit packed operand vectors and returns, lane by lane, the magnitude of the difference between matching lanes of the first and second operand. A 2-bit size code sets the lane width at run time to 8, 16 or 32 bits. A signedness control reads the lanes either as unsigned values or as two's-complement values. A form control selects a full 128-bit vector or only the low 64-bit half. A widening mode takes the low 64 bits of each operand and writes result lanes that are twice as wide and hold the exact magnitude.

The unit has no backpressure. Operands and controls come in with `in_valid`. The result, a matching `out_valid` pulse and an illegal-combination flag appear one clock later. Between accepted operations the output register keeps its value. The operation has no condition-flag outputs. The unit would sit behind an instruction decoder that supplies the control fields. Register files and decode are not part of it.

Top module: `simd_absdiff`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `out_valid` and `out_illegal` are 0 and `out_data` is zero.
- R2: With `in_size` 2'b00, 2'b01 or 2'b10, lanes are 8, 16 or 32 bits wide. Lane e occupies bits [e*w +: w] of the operands and of the result. In the non-widening unsigned 128-bit form, each result lane is |a-b|, truncated to w bits.
- R3: With `in_signed`=1, each lane is read as a two's-complement integer before the subtraction. For example, the 8-bit lanes 0x80 and 0x7F give 0xFF. With `in_signed`=0, the lanes are read as unsigned.
- R4: With `in_widen`=1 and `in_quad`=0, only bits [63:0] of each operand are used. Result lane e is 2*w bits wide at [e*2w +: 2w] and holds the exact magnitude. With 32-bit lanes this gives two 64-bit results.
- R5: With `in_quad`=0 and `in_widen`=0, only bits [63:0] of each operand are processed, and result bits [127:64] are zero.
- R6: `in_size`=2'b11, or `in_widen`=1 together with `in_quad`=1, is illegal. Such an operation sets `out_illegal`=1 with `out_data` zero. A legal operation clears `out_illegal`.
- R7: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1, and 0 otherwise.
- R8: In a cycle after one where `in_valid` is 0, `out_data` and `out_illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls present this cycle |
| in_a | input | 128 | First operand vector (minuend) |
| in_b | input | 128 | Second operand vector (subtrahend) |
| in_size | input | 2 | Lane width code: 00=8, 01=16, 10=32, 11 illegal |
| in_signed | input | 1 | 1 = two's-complement lanes, 0 = unsigned |
| in_quad | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| in_widen | input | 1 | 1 = double-width result lanes from the low 64 bits |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 128 | Packed absolute-difference result |
| out_illegal | output | 1 | Illegal control combination was requested |

## Verification
A wrong lane slice or a wrong width select corrupts specific bit ranges of `out_data` in the cycle right after the operation is accepted. The scoreboard, with a per-lane reference model, catches this on the first operation with differing lanes. A wrong sign extension shows up only when a lane's top bit is set, so the extreme patterns (minimum and maximum signed, all ones, zero) are driven in every combination of size, signedness, form and widening. A broken capture enable or valid register shows up one cycle later as a missing or extra `out_valid` pulse, or as output data that changes during idle cycles.

// File: rtl/simd_absdiff_pkg.sv
package simd_absdiff_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_H16 = 2'b01,
    SZ_W32 = 2'b10,
    SZ_BAD = 2'b11
  } lane_size_e;

  localparam int unsigned NUM_SIZES = 3;
  localparam int unsigned MIN_LANE_W = 8;

  function automatic int unsigned lane_bits(input int unsigned idx);
    return MIN_LANE_W << idx;
  endfunction

endpackage

// File: rtl/simd_absdiff_lane.sv
module simd_absdiff_lane #(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic          signed_i,
  output logic [LW-1:0] mag_o
);

  logic [LW:0] a_ext;
  logic [LW:0] b_ext;
  logic [LW:0] diff;

  always_comb begin
    a_ext = {signed_i & a_i[LW-1], a_i};
    b_ext = {signed_i & b_i[LW-1], b_i};
    diff  = a_ext - b_ext;
    // magnitude never exceeds 2^LW-1, so LW bits hold it exactly
    mag_o = diff[LW] ? (~diff[LW-1:0] + 1'b1) : diff[LW-1:0];
  end

endmodule

// File: rtl/simd_absdiff_bank.sv
module simd_absdiff_bank #(
  parameter int unsigned LW    = 8,
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             signed_i,
  output logic [VEC_W-1:0] mag_o
);

  localparam int unsigned NL = VEC_W / LW;

  for (genvar e = 0; e < NL; e++) begin : g_lane
    simd_absdiff_lane #(.LW(LW)) u_lane (
      .a_i      (a_i[e*LW +: LW]),
      .b_i      (b_i[e*LW +: LW]),
      .signed_i (signed_i),
      .mag_o    (mag_o[e*LW +: LW])
    );
  end

endmodule

// File: rtl/simd_absdiff_widen.sv
module simd_absdiff_widen #(
  parameter int unsigned LW    = 8,
  parameter int unsigned SRC_W = 64
) (
  input  logic [SRC_W-1:0]   narrow_i,
  output logic [2*SRC_W-1:0] wide_o
);

  localparam int unsigned NL = SRC_W / LW;

  for (genvar e = 0; e < NL; e++) begin : g_spread
    assign wide_o[e*2*LW +: 2*LW] = {{LW{1'b0}}, narrow_i[e*LW +: LW]};
  end

endmodule

// File: rtl/simd_absdiff.sv
module simd_absdiff
  import simd_absdiff_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_size,
  input  logic              in_signed,
  input  logic              in_quad,
  input  logic              in_widen,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] narrow_res [NUM_SIZES];
  logic [DATA_W-1:0] wide_res   [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int unsigned LW = lane_bits(g);

    simd_absdiff_bank #(.LW(LW), .VEC_W(DATA_W)) u_bank (
      .a_i      (in_a),
      .b_i      (in_b),
      .signed_i (in_signed),
      .mag_o    (narrow_res[g])
    );

    simd_absdiff_widen #(.LW(LW), .SRC_W(HALF_W)) u_widen (
      .narrow_i (narrow_res[g][HALF_W-1:0]),
      .wide_o   (wide_res[g])
    );
  end

  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] data_nx;
  logic              illegal_nx;
  logic              cap_en;

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              illegal_q;

  always_comb begin
    illegal_nx = (lane_size_e'(in_size) == SZ_BAD) | (in_widen & in_quad);
    unique case (lane_size_e'(in_size))
      SZ_B8:   picked = in_widen ? wide_res[0] : narrow_res[0];
      SZ_H16:  picked = in_widen ? wide_res[1] : narrow_res[1];
      SZ_W32:  picked = in_widen ? wide_res[2] : narrow_res[2];
      default: picked = '0;
    endcase
    data_nx = picked;
    if (!in_quad && !in_widen) begin
      data_nx[DATA_W-1:HALF_W] = '0;
    end
    if (illegal_nx) begin
      data_nx = '0;
    end
    cap_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      data_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (cap_en) begin
        data_q    <= data_nx;
        illegal_q <= illegal_nx;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_data    = data_q;
  assign out_illegal = illegal_q;

endmodule

// File: rtl/simd_absdiff_chk.sv
module simd_absdiff_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_size,
  input logic              in_quad,
  input logic              in_widen,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);

  localparam int unsigned HALF_W = DATA_W / 2;

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_data == '0));

  // R6
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_size == 2'b11 || (in_widen && in_quad))) |=> out_illegal);

  // R5
  half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_quad && !in_widen) |=> (out_data[DATA_W-1:HALF_W] == '0));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));

endmodule

bind simd_absdiff simd_absdiff_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_size     (in_size),
  .in_quad     (in_quad),
  .in_widen    (in_widen),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/simd_absdiff_test.sv
`timescale 1ns/1ps
module simd_absdiff_test;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_a;
  logic [127:0] in_b;
  logic [1:0]   in_size;
  logic         in_signed;
  logic         in_quad;
  logic         in_widen;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    logic [127:0] data;
    logic         ill;
    string        tag;
  } exp_t;

  exp_t sb_q[$];

  simd_absdiff uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_size(in_size), .in_signed(in_signed), .in_quad(in_quad),
    .in_widen(in_widen), .out_valid(out_valid), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz, input logic sg,
                                         input logic qd, input logic wd,
                                         output logic ill);
    logic [127:0] r = '0;
    int esize, n, rw;
    longint unsigned mask;
    ill = (sz == 2'b11) || (wd && qd);
    if (ill) return '0;
    esize = 8 << sz;
    rw    = wd ? 2 * esize : esize;
    n     = wd ? 64 / esize : (qd ? 128 : 64) / esize;
    mask  = (64'd1 << esize) - 1;
    for (int e = 0; e < n; e++) begin
      logic [127:0] ta, tb, part;
      longint unsigned ux, uy;
      longint sx, sy, d;
      ta = a >> (e * esize);
      tb = b >> (e * esize);
      ux = ta[63:0] & mask;
      uy = tb[63:0] & mask;
      sx = longint'(ux);
      sy = longint'(uy);
      if (sg && ux[esize-1]) sx = sx - (longint'(1) << esize);
      if (sg && uy[esize-1]) sy = sy - (longint'(1) << esize);
      d = sx - sy;
      if (d < 0) d = -d;
      if (!wd) d = d & longint'(mask);
      part = 128'(d);
      r = r | (part << (e * rw));
    end
    return r;
  endfunction

  function automatic logic [127:0] rep(input longint unsigned v, input int esize);
    logic [127:0] r = '0;
    for (int i = 0; i < 128 / esize; i++) r = r | (128'(v) << (i * esize));
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // driver: leaves in_valid high at the following negedge
  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                      input logic sg, input logic qd, input logic wd);
    exp_t it;
    logic il;
    it.data = model(a, b, sz, sg, qd, wd, il);
    it.ill  = il;
    if (il)        it.tag = "R6";
    else if (wd)   it.tag = "R4";
    else if (!qd)  it.tag = "R5";
    else if (sg)   it.tag = "R3";
    else           it.tag = "R2";
    sb_q.push_back(it);
    in_a = a; in_b = b; in_size = sz; in_signed = sg; in_quad = qd; in_widen = wd;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected out_valid", 128'(out_valid), 128'(0));
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check(out_data == it.data, it.tag, out_data, it.data);
        check(out_illegal == it.ill, {it.tag, " illegal flag"},
              128'(out_illegal), 128'(it.ill));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_a = '0; in_b = '0; in_size = '0;
    in_signed = 0; in_quad = 0; in_widen = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 0 && out_illegal == 0, "R1 flags in reset",
          {126'd0, out_valid, out_illegal}, 128'd0);
    check(out_data == '0, "R1 data in reset", out_data, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && out_illegal == 0, "R1 flags after release",
          {126'd0, out_valid, out_illegal}, 128'd0);

    // R7 / R8 latency and hold
    begin
      logic [127:0] held;
      send(rep(64'h05, 8), rep(64'h03, 8), 2'b00, 1'b0, 1'b1, 1'b0);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R7 valid one cycle later", 128'(out_valid), 128'd1);
      held = out_data;
      @(negedge clk);
      check(out_valid == 1'b0, "R7 valid drops", 128'(out_valid), 128'd0);
      in_a = rnd128(); in_b = rnd128(); in_size = 2'b11;
      @(negedge clk);
      check(out_data == held && out_illegal == 1'b0, "R8 result held while idle",
            out_data, held);
    end

    // sweep all control combinations with extreme and random patterns
    for (int sz = 0; sz < 4; sz++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int qd = 0; qd < 2; qd++) begin
          for (int wd = 0; wd < 2; wd++) begin
            int es;
            longint unsigned mx, mn, ms;
            es = (sz == 3) ? 8 : (8 << sz);
            mx = (64'd1 << es) - 1;
            mn = 64'd1 << (es - 1);
            ms = mn - 1;
            send(rep(mx, es), rep(0, es), 2'(sz), sg[0], qd[0], wd[0]);
            send(rep(0, es), rep(mx, es), 2'(sz), sg[0], qd[0], wd[0]);
            send(rep(mn, es), rep(ms, es), 2'(sz), sg[0], qd[0], wd[0]);
            send(rep(ms, es), rep(mn, es), 2'(sz), sg[0], qd[0], wd[0]);
            send(rep(mn, es), rep(mx, es), 2'(sz), sg[0], qd[0], wd[0]);
            send(rnd128(), rnd128(), 2'(sz), sg[0], qd[0], wd[0]);
            send(rnd128(), rnd128(), 2'(sz), sg[0], qd[0], wd[0]);
            idle(1);
          end
        end
      end
    end

    // illegal followed by legal clears the flag (R6)
    send(rnd128(), rnd128(), 2'b11, 1'b0, 1'b1, 1'b0);
    send(rep(64'h10, 16), rep(64'h01, 16), 2'b01, 1'b0, 1'b1, 1'b0);
    idle(3);

    check(sb_q.size() == 0, "R7 all results delivered", 128'(sb_q.size()), 128'd0);
    finished = 1;
    summary();
    $finish;
  end

endmodule